// File: doc/BRIEF.md
# Multi-Level DMA Channel Arbiter

This block chooses which of several DMA channels may move data next. It does not move data itself. Each channel carries a two-bit priority level, and each of the four levels can be switched on or off. Within a level, one configuration bit picks either lowest-index-first selection or rotating (round-robin) selection.

The block keeps a pending flag and a busy flag for every channel, and an executing flag for every level. Only one channel is active at a time. A new decision is made when nothing is active, when the active channel reports the end of its burst, or when the active channel is suspended or disabled. At the end of a burst, the active channel can ask to go back into contention, and it then competes in that same decision.

Top module: `dma_level_arbiter`

## Requirements
- R1: After a clock edge with `rst_n` low, no channel is active, `grant_vld_o` is low, and `pend_o`, `busy_o` and `lvl_exec_o` are all zero. The round-robin search of every level starts at channel 0.
- R2: A request on an enabled channel sets its pending flag at the next edge. A request on a disabled channel is ignored. A request that arrives in the same cycle the channel is granted leaves the channel pending.
- R3: The channel level for channel c is the field `chan_lvl_i[2c+1:2c]`. The highest-numbered enabled level that holds an eligible channel wins. A level whose bit in `lvl_en_i` is 0 is never granted, although its channels stay pending.
- R4: When the `lvl_rr_i` bit of the winning level is 0, the lowest-numbered eligible channel of that level is granted.
- R5: When the `lvl_rr_i` bit of the winning level is 1, the search starts one channel above the last channel granted from that level and wraps around. The level's pointer moves only when that level wins.
- R6: A decision is taken only when no channel is active, when `burst_done_i` is high, or when the active channel is suspended or disabled. A grant makes `act_vld_o` high with the channel number on `act_ch_o`, and pulses `grant_vld_o` for one cycle.
- R7: A granted channel's busy flag is set and its pending flag is cleared. When `burst_done_i` and `burst_more_i` are both high, the active channel keeps its busy flag, becomes pending again, and takes part in that same decision.
- R8: When `burst_done_i` is high and `burst_more_i` is low, the active channel's busy flag clears. The channel then waits for a new request.
- R9: While a channel's suspend bit is high, it is never granted, its pending flag is kept and its busy flag is cleared. A suspended active channel is released and marked pending. When the suspend bit falls, the channel can be granted again.
- R10: Disabling a channel clears its pending and busy flags. If the channel was active, it is released.
- R11: `lvl_exec_o[l]` is high exactly when some channel whose level is l is pending or active.
- R12: When every channel sits on one round-robin level and each burst asks for more, every channel is granted exactly once in each run of N consecutive grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NCH | Per-channel transfer request pulse |
| chan_en_i | input | NCH | Per-channel enable |
| chan_susp_i | input | NCH | Per-channel suspend (level-sensitive) |
| chan_lvl_i | input | 2*NCH | Two-bit priority level per channel |
| lvl_en_i | input | 4 | Per-level enable |
| lvl_rr_i | input | 4 | Per-level round-robin select (1) or fixed (0) |
| burst_done_i | input | 1 | Active channel finished its burst |
| burst_more_i | input | 1 | With burst done: channel has more to transfer |
| grant_vld_o | output | 1 | One-cycle pulse on a new grant |
| act_vld_o | output | 1 | A channel is active |
| act_ch_o | output | log2(NCH) | Number of the active channel |
| pend_o | output | NCH | Pending flags |
| busy_o | output | NCH | Busy flags |
| lvl_exec_o | output | 4 | Per-level executing flags |

## Verification
The assertions assume that `burst_done_i` is raised only while a channel is active, and that `burst_more_i` matters only in the same cycle as `burst_done_i`. The bench holds a cycle-level model of the flags and pointers. It raises burst done only when that model shows an active channel. Requests, enables, suspends, levels and mode bits are free to change on any cycle, including the cycle in which the active channel is being released. Directed scenes cover each corner in a clean state after a reset. A long sweep driven by random patterns then compares every output with the model.

// File: rtl/dmarb_pkg.sv
// Shared constants and types for the DMA level arbiter.
// Assumes a fixed two-bit priority level, so four levels exist.
package dmarb_pkg;
    localparam int LVL_W = 2;
    localparam int NLVL  = 1 << LVL_W;
    typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/dmarb_lvl_pick.sv
// Picks one candidate among the channels of a single priority level.
// Uses lowest-index-first in fixed mode, or a rotating search that starts
// above the last winner in round-robin mode.
// Assumes win_i is high only in a cycle where hit_o is high and the level
// won the overall decision.
module dmarb_lvl_pick #(
    parameter int NCH = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cand_i,
    input  logic           rr_en_i,
    input  logic           win_i,
    output logic           hit_o,
    output logic [CW-1:0]  idx_o
);
    logic [CW-1:0] ptr_q;
    logic          found;
    logic [CW-1:0] probe;

    // Search the candidates in the order the selected mode dictates.
    always_comb begin
        hit_o = |cand_i;
        idx_o = '0;
        found = 1'b0;
        probe = '0;
        for (int k = 1; k <= NCH; k++) begin
            if (rr_en_i) probe = CW'((int'(ptr_q) + k) % NCH);
            else         probe = CW'(k - 1);
            if (!found && cand_i[probe]) begin
                idx_o = probe;
                found = 1'b1;
            end
        end
    end

    // Remember the last winner of this level; the reset value starts the search at 0.
    always_ff @(posedge clk) begin
        if (!rst_n)               ptr_q <= CW'(NCH - 1);
        else if (win_i && hit_o)  ptr_q <= idx_o;
    end

    // R5
    rr_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_i |=> $stable(ptr_q));
    // R4
    pick_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> cand_i[idx_o]);
endmodule

// File: rtl/dmarb_lvl_sel.sv
// Chooses the highest-numbered level that is enabled and holds a candidate.
// Assumes that hit_i already reflects only the eligible channels of each level.
module dmarb_lvl_sel
    import dmarb_pkg::*;
(
    input  logic [NLVL-1:0] hit_i,
    input  logic [NLVL-1:0] lvl_en_i,
    output logic            any_o,
    output lvl_t            lvl_o
);
    // Scan upward so that the highest qualifying level is the one that remains.
    always_comb begin
        any_o = 1'b0;
        lvl_o = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (hit_i[l] && lvl_en_i[l]) begin
                any_o = 1'b1;
                lvl_o = lvl_t'(l);
            end
        end
    end
endmodule

// File: rtl/dma_level_arbiter.sv
// Grants one DMA channel at a time, choosing among pending channels by level.
// Holds the pending and busy flags of every channel and the active channel.
// Assumes burst_done_i is raised only while a channel is active.
module dma_level_arbiter
    import dmarb_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       req_i,
    input  logic [NCH-1:0]       chan_en_i,
    input  logic [NCH-1:0]       chan_susp_i,
    input  logic [NCH*LVL_W-1:0] chan_lvl_i,
    input  logic [NLVL-1:0]      lvl_en_i,
    input  logic [NLVL-1:0]      lvl_rr_i,
    input  logic                 burst_done_i,
    input  logic                 burst_more_i,
    output logic                 grant_vld_o,
    output logic                 act_vld_o,
    output logic [CW-1:0]        act_ch_o,
    output logic [NCH-1:0]       pend_o,
    output logic [NCH-1:0]       busy_o,
    output logic [NLVL-1:0]      lvl_exec_o
);
    lvl_t           ch_lvl [NCH];
    logic [NCH-1:0] pend_q, pend_d, busy_q, busy_d;
    logic           act_vld_q, act_vld_d, grant_q;
    logic [CW-1:0]  act_ch_q, act_ch_d;
    logic           release_act, requeue_act, decide, grant;
    logic [NCH-1:0] act_oh, cand;
    logic [NCH-1:0] lvl_cand [NLVL];
    logic [NLVL-1:0] lvl_hit, lvl_win;
    logic [CW-1:0]  lvl_idx [NLVL];
    logic           sel_any;
    lvl_t           sel_lvl;
    logic [CW-1:0]  win_idx;

    // Split the flat level vector into one field per channel.
    always_comb begin
        for (int i = 0; i < NCH; i++) ch_lvl[i] = chan_lvl_i[i*LVL_W +: LVL_W];
    end

    // Work out when to decide and which channels may compete.
    always_comb begin
        act_oh      = act_vld_q ? (NCH'(1) << act_ch_q) : '0;
        release_act = act_vld_q && (!chan_en_i[act_ch_q] || chan_susp_i[act_ch_q]);
        requeue_act = act_vld_q && burst_done_i && burst_more_i && !release_act;
        decide      = !act_vld_q || burst_done_i || release_act;
        cand        = (pend_q | (requeue_act ? act_oh : '0)) & chan_en_i & ~chan_susp_i;
        for (int l = 0; l < NLVL; l++) begin
            for (int i = 0; i < NCH; i++) lvl_cand[l][i] = cand[i] && (ch_lvl[i] == lvl_t'(l));
        end
    end

    generate
        for (genvar g = 0; g < NLVL; g++) begin : g_lvl
            dmarb_lvl_pick #(.NCH(NCH)) u_pick (
                .clk     (clk),
                .rst_n   (rst_n),
                .cand_i  (lvl_cand[g]),
                .rr_en_i (lvl_rr_i[g]),
                .win_i   (lvl_win[g]),
                .hit_o   (lvl_hit[g]),
                .idx_o   (lvl_idx[g])
            );
        end
    endgenerate

    dmarb_lvl_sel u_sel (
        .hit_i    (lvl_hit),
        .lvl_en_i (lvl_en_i),
        .any_o    (sel_any),
        .lvl_o    (sel_lvl)
    );

    // Combine the level choice into a grant and tell the winning level.
    always_comb begin
        grant   = decide && sel_any;
        win_idx = lvl_idx[sel_lvl];
        for (int l = 0; l < NLVL; l++) lvl_win[l] = grant && (sel_lvl == lvl_t'(l));
    end

    // Next state of the pending and busy flags and of the active channel.
    always_comb begin
        pend_d    = pend_q;
        busy_d    = busy_q;
        act_vld_d = act_vld_q;
        act_ch_d  = act_ch_q;
        if (requeue_act) pend_d[act_ch_q] = 1'b1;
        if (release_act && chan_susp_i[act_ch_q]) pend_d[act_ch_q] = 1'b1;
        if (act_vld_q && burst_done_i && !burst_more_i) busy_d[act_ch_q] = 1'b0;
        if (grant) begin
            pend_d[win_idx] = 1'b0;
            busy_d[win_idx] = 1'b1;
        end
        pend_d = (pend_d | req_i) & chan_en_i;
        busy_d = busy_d & chan_en_i & ~chan_susp_i;
        if (decide) begin
            act_vld_d = grant;
            if (grant) act_ch_d = win_idx;
        end
    end

    // Register the state of the arbiter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            busy_q    <= '0;
            act_vld_q <= 1'b0;
            act_ch_q  <= '0;
            grant_q   <= 1'b0;
        end else begin
            pend_q    <= pend_d;
            busy_q    <= busy_d;
            act_vld_q <= act_vld_d;
            act_ch_q  <= act_ch_d;
            grant_q   <= grant;
        end
    end

    // Raise a level's executing flag while any of its channels is pending or active.
    always_comb begin
        for (int l = 0; l < NLVL; l++) begin
            lvl_exec_o[l] = 1'b0;
            for (int i = 0; i < NCH; i++) begin
                if (ch_lvl[i] == lvl_t'(l) && (pend_q[i] || act_oh[i])) lvl_exec_o[l] = 1'b1;
            end
        end
    end

    assign grant_vld_o = grant_q;
    assign act_vld_o   = act_vld_q;
    assign act_ch_o    = act_ch_q;
    assign pend_o      = pend_q;
    assign busy_o      = busy_q;

    // R6
    grant_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_q |-> act_vld_q);
    // R6
    hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_vld_q && !burst_done_i && chan_en_i[act_ch_q] && !chan_susp_i[act_ch_q])
        |=> (act_vld_q && $stable(act_ch_q)));
    // R6
    burst_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done_i |-> act_vld_q);
    // R7
    grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_q |-> busy_q[act_ch_q]);
    // R10
    no_pend_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(chan_en_i)) == '0));
    // R3
    sel_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_any |-> (lvl_en_i[sel_lvl] && lvl_hit[sel_lvl]));
endmodule

// File: tb/tb_dma_level_arbiter.sv
`timescale 1ns/1ps
module tb_dma_level_arbiter;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  req = '0, en = '1, susp = '0;
    logic [15:0] lvl_vec = '0;
    logic [3:0]  lvl_en = '1, rr = '0;
    logic        bd = 1'b0, more = 1'b0;
    logic        grant_vld, act_vld;
    logic [2:0]  act_ch;
    logic [7:0]  pend, busy;
    logic [3:0]  lvl_exec;

    int nchk = 0, nbad = 0;
    bit [7:0] m_pend, m_busy, n_pend, n_busy;
    bit       m_act, m_gnt, n_act, n_gnt;
    int       m_ach, n_ach;
    int       m_ptr [4];
    int       n_ptr [4];
    int       cnt [8];

    always #4 clk = ~clk;

    dma_level_arbiter #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .chan_en_i(en), .chan_susp_i(susp),
        .chan_lvl_i(lvl_vec), .lvl_en_i(lvl_en), .lvl_rr_i(rr),
        .burst_done_i(bd), .burst_more_i(more),
        .grant_vld_o(grant_vld), .act_vld_o(act_vld), .act_ch_o(act_ch),
        .pend_o(pend), .busy_o(busy), .lvl_exec_o(lvl_exec)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int lvlof(int c);
        return int'(lvl_vec[c*2 +: 2]);
    endfunction

    task automatic set_lvl(int c, int v);
        lvl_vec[c*2 +: 2] = 2'(v);
    endtask

    // Model of the flags, computed from the inputs currently applied.
    task automatic model_step();
        bit rel, rq, dec, g;
        bit [7:0] cand;
        int bl, bc;
        bl = -1; bc = -1;
        rel  = m_act && (!en[m_ach] || susp[m_ach]);
        rq   = m_act && bd && more && !rel;
        dec  = !m_act || bd || rel;
        cand = m_pend;
        if (rq) cand[m_ach] = 1'b1;
        cand = cand & en & ~susp;
        for (int l = 3; l >= 0; l--) begin
            if (bl < 0 && lvl_en[l]) begin
                for (int k = 1; k <= 8; k++) begin
                    int c;
                    c = rr[l] ? (m_ptr[l] + k) % 8 : k - 1;
                    if (bc < 0 && cand[c] && lvlof(c) == l) bc = c;
                end
                if (bc >= 0) bl = l;
            end
        end
        g = dec && (bl >= 0);
        n_pend = m_pend; n_busy = m_busy; n_act = m_act; n_ach = m_ach;
        n_ptr = m_ptr;
        if (rq) n_pend[m_ach] = 1'b1;
        if (rel && susp[m_ach]) n_pend[m_ach] = 1'b1;
        if (m_act && bd && !more) n_busy[m_ach] = 1'b0;
        if (g) begin
            n_pend[bc] = 1'b0;
            n_busy[bc] = 1'b1;
            n_ptr[bl]  = bc;
        end
        n_pend = (n_pend | req) & en;
        n_busy = n_busy & en & ~susp;
        if (dec) begin
            n_act = g;
            if (g) n_ach = bc;
        end
        n_gnt = g;
    endtask

    task automatic compare();
        bit [3:0] ex;
        ex = '0;
        for (int c = 0; c < 8; c++)
            if (m_pend[c] || (m_act && m_ach == c)) ex[lvlof(c)] = 1'b1;
        chk(act_vld == m_act, "R6 active", int'(act_vld), int'(m_act));
        if (m_act) chk(act_ch == 3'(m_ach), "R6 channel", int'(act_ch), m_ach);
        chk(grant_vld == m_gnt, "R6 grant pulse", int'(grant_vld), int'(m_gnt));
        chk(pend == m_pend, "R2 pending", int'(pend), int'(m_pend));
        chk(busy == m_busy, "R7 busy", int'(busy), int'(m_busy));
        chk(lvl_exec == ex, "R11 executing", int'(lvl_exec), int'(ex));
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #2;
        m_pend = n_pend; m_busy = n_busy; m_act = n_act; m_ach = n_ach;
        m_gnt = n_gnt; m_ptr = n_ptr;
        compare();
    endtask

    task automatic burst(bit mo);
        bd = 1'b1; more = mo;
        tick();
        bd = 1'b0; more = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = '0; bd = 1'b0; more = 1'b0;
        en = '1; susp = '0; lvl_vec = '0; lvl_en = '1; rr = '0;
        repeat (2) @(posedge clk);
        #2;
        rst_n = 1'b1;
        m_pend = '0; m_busy = '0; m_act = 1'b0; m_ach = 0; m_gnt = 1'b0;
        for (int l = 0; l < 4; l++) m_ptr[l] = 7;
        chk(act_vld == 1'b0 && grant_vld == 1'b0, "R1 idle", int'(act_vld), 0);
        chk(pend == '0 && busy == '0, "R1 flags", int'({pend, busy}), 0);
        chk(lvl_exec == '0, "R1 executing", int'(lvl_exec), 0);
    endtask

    initial begin
        #1_000_000;
        nbad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        // R4: fixed order inside one level
        do_reset();
        set_lvl(2, 1); set_lvl(5, 1); set_lvl(6, 1);
        req = 8'b0110_0100; tick(); req = '0;
        tick();
        chk(grant_vld && act_ch == 3'd2, "R4 lowest first", int'(act_ch), 2);
        burst(1'b0);
        chk(act_ch == 3'd5, "R4 next lowest", int'(act_ch), 5);
        chk(busy[2] == 1'b0, "R8 busy cleared", int'(busy[2]), 0);
        burst(1'b0);
        burst(1'b0);
        chk(act_vld == 1'b0, "R8 waits for request", int'(act_vld), 0);

        // R3: level order and level enable
        do_reset();
        set_lvl(4, 2); set_lvl(7, 3);
        lvl_en = 4'b0111;
        req = 8'b1001_0010; tick(); req = '0;
        tick();
        chk(act_ch == 3'd4, "R3 higher enabled level", int'(act_ch), 4);
        burst(1'b0);
        chk(act_ch == 3'd1, "R3 lower level next", int'(act_ch), 1);
        burst(1'b0);
        chk(act_vld == 1'b0 && pend[7], "R3 disabled level held", int'({act_vld, pend[7]}), 1);
        lvl_en = 4'b1111;
        tick();
        chk(grant_vld && act_ch == 3'd7, "R3 level re-enabled", int'(act_ch), 7);
        burst(1'b0);

        // R5: rotating search within a level
        do_reset();
        for (int c = 0; c < 8; c++) set_lvl(c, 2);
        rr = 4'b0100;
        req = 8'b0010_1000; tick(); req = '0;
        tick();
        chk(act_ch == 3'd3, "R5 first from channel 0", int'(act_ch), 3);
        burst(1'b1);
        chk(act_ch == 3'd5, "R5 above pointer", int'(act_ch), 5);
        chk(busy[3] && pend[3], "R7 requeue keeps busy", int'({busy[3], pend[3]}), 3);
        burst(1'b1);
        chk(act_ch == 3'd3, "R5 wrap around", int'(act_ch), 3);
        burst(1'b0);
        chk(act_ch == 3'd5, "R5 remaining", int'(act_ch), 5);
        burst(1'b0);

        // R9: suspend and resume
        do_reset();
        req = 8'b0100_0001; tick(); req = '0;
        susp[0] = 1'b1;
        tick();
        chk(act_ch == 3'd6 && pend[0], "R9 suspended skipped", int'({act_ch, pend[0]}), 13);
        burst(1'b0);
        chk(act_vld == 1'b0 && pend[0], "R9 pending kept", int'({act_vld, pend[0]}), 1);
        susp[0] = 1'b0;
        tick();
        chk(grant_vld && act_ch == 3'd0, "R9 resumed", int'(act_ch), 0);
        susp[0] = 1'b1;
        tick();
        chk(!act_vld && !busy[0] && pend[0], "R9 active released",
            int'({act_vld, busy[0], pend[0]}), 1);
        susp[0] = 1'b0;
        tick();
        chk(grant_vld && act_ch == 3'd0, "R9 regranted", int'(act_ch), 0);
        burst(1'b0);

        // R10: disable, R2: requests
        do_reset();
        req = 8'b0000_1100; tick(); req = '0;
        tick();
        chk(act_ch == 3'd2, "R10 setup", int'(act_ch), 2);
        en[3] = 1'b0;
        tick();
        chk(pend[3] == 1'b0, "R10 pending cleared", int'(pend[3]), 0);
        en[3] = 1'b1; en[2] = 1'b0;
        tick();
        chk(!act_vld && !busy[2] && !pend[2], "R10 active dropped",
            int'({act_vld, busy[2], pend[2]}), 0);
        req = 8'b0000_0100;
        tick();
        chk(pend[2] == 1'b0, "R2 disabled request ignored", int'(pend[2]), 0);
        req = 8'b0001_0000; en = '1;
        tick();
        req = '0;
        chk(pend[4] == 1'b1, "R2 request latched", int'(pend[4]), 1);

        // R12: no starvation under rotation
        do_reset();
        for (int c = 0; c < 8; c++) begin set_lvl(c, 1); cnt[c] = 0; end
        rr = 4'b0010;
        req = '1; tick(); req = '0;
        chk(lvl_exec == 4'b0010, "R11 level flag", int'(lvl_exec), 2);
        tick();
        if (grant_vld) cnt[act_ch]++;
        for (int n = 0; n < 31; n++) begin
            bd = 1'b1; more = 1'b1;
            tick();
            if (grant_vld) cnt[act_ch]++;
        end
        bd = 1'b0; more = 1'b0;
        for (int c = 0; c < 8; c++) chk(cnt[c] == 4, "R12 fair share", cnt[c], 4);

        // Random sweep against the model
        do_reset();
        for (int n = 0; n < 6000; n++) begin
            req  = 8'($urandom & $urandom & $urandom);
            bd   = m_act && ($urandom % 3 == 0);
            more = bd && ($urandom % 2 == 0);
            if ($urandom % 20 == 0) en[$urandom % 8] ^= 1'b1;
            if ($urandom % 15 == 0) susp[$urandom % 8] ^= 1'b1;
            if ($urandom % 30 == 0) set_lvl($urandom % 8, $urandom % 4);
            if ($urandom % 25 == 0) lvl_en = 4'($urandom) | 4'b0001;
            if ($urandom % 40 == 0) rr = 4'($urandom);
            tick();
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule